// File: doc/BRIEF.md
# Graphics Memory Block-Write Engine

This block is the graphics write path of a small behavioural 32-bit memory row. It stores a fill colour and a persistent bit-plane write mask. Both are loaded by a register-load command. Ordinary writes go through the bit-plane mask and through a per-byte lane mask. A block write fills up to eight aligned neighbouring columns with the stored colour in a single cycle. During that cycle the data bus carries a per-column enable mask rather than data.

One command is presented per clock on `cmd`. The row must be opened before array commands take effect, and it is closed either by an explicit close command or by the auto-closing form of block write. The minimum spacings after a register load, and after a block write, are parameters counted in clock cycles. A command that arrives too early is dropped, and `timing_err` pulses for one cycle. Reads return one column word one cycle later, so the array can be inspected.

Top module: `bwe_engine`

## Requirements
- R1: Command codes on `cmd` are 0 idle, 1 open row, 2 write, 3 block write, 4 block write with auto-close, 5 register load, 6 close row, 7 read. After reset the row is closed, `timing_err` and `rd_valid` are low, every column holds 0, the colour register is 0 and the bit-plane mask is all ones.
- R2: Code 1 opens the row and code 6 closes it. Codes 2, 3, 4 and 7 have no effect while the row is closed.
- R3: A write to column `col_addr` changes only those bits that are set in the bit-plane mask and that lie in a byte lane whose `dqm` bit is 0. Lane i covers bits 8i+7..8i. The other bits keep their old value.
- R4: A register load with `col_addr[0]`=0 stores `dq_in` as the colour; with `col_addr[0]`=1 it stores `dq_in` as the bit-plane mask. The mask stays in force for every later write until the next load.
- R5: After an accepted register load, any non-idle command during the next RSC_CYC-1 cycles is a violation.
- R6: A block write ignores `col_addr[2:0]` and targets columns base..base+7, where base is `col_addr` with its low three bits cleared. Column base+k is written with the colour only when `dq_in[k]` is 1.
- R7: Within each enabled column of a block write, the bit-plane mask and the `dqm` lanes restrict the changed bits exactly as in R3.
- R8: An accepted code-4 block write closes the row, which is visible as `row_open` low in the next cycle.
- R9: After an accepted block write (code 3 or 4), a code 2, 3, 4 or 5 during the next BWC_CYC-1 cycles is a violation. After an accepted code-3 block write, a code 6 during the next BPL_CYC-1 cycles is a violation.
- R10: An accepted read drives the word held in column `col_addr` on `rd_data` in the next cycle, with `rd_valid` high for that one cycle.
- R11: A violating command has no effect, and `timing_err` is high for exactly the one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code (see R1) |
| col_addr | input | COL_W | Column address; bit 0 selects the register for a load |
| dq_in | input | 32 | Write data, load value, or block-write column enables |
| dqm | input | 4 | Byte-lane write masks, 1 = lane masked |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | Read word valid |
| row_open | output | 1 | Row currently open |
| timing_err | output | 1 | Spacing violation pulse |

## Verification
The properties watch, on every cycle, the following things. `timing_err` only follows a real command. Load and block-write guard windows turn early commands into violations. At most one array operation fires at a time. The colour and mask registers hold between loads. The auto-close form shuts the row. `rd_valid` tracks an accepted read. The bench scenarios are what show the data itself: the merge of the mask and the lanes, the alignment and per-column selection of a block write, colour persistence across commands, and that dropped commands leave the array unchanged. The bench compares against its own bit-by-bit model of the array.

// File: rtl/bwe_pkg.sv
package bwe_pkg;

  localparam int unsigned DQ_W   = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = DQ_W / LANE_W;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_WR   = 3'd2,
    OP_BW   = 3'd3,
    OP_BWAP = 3'd4,
    OP_LOAD = 3'd5,
    OP_PRE  = 3'd6,
    OP_RD   = 3'd7
  } op_e;

  // Bits allowed to change: plane mask bits in lanes that are not masked off.
  function automatic logic [DQ_W-1:0] bit_enable(input logic [DQ_W-1:0]  plane,
                                                 input logic [LANES-1:0] lane_off);
    logic [DQ_W-1:0] en;
    for (int i = 0; i < LANES; i++) begin
      en[i*LANE_W +: LANE_W] = lane_off[i] ? '0 : plane[i*LANE_W +: LANE_W];
    end
    return en;
  endfunction

  function automatic logic [DQ_W-1:0] merge_word(input logic [DQ_W-1:0] old_w,
                                                 input logic [DQ_W-1:0] new_w,
                                                 input logic [DQ_W-1:0] en);
    return (old_w & ~en) | (new_w & en);
  endfunction

endpackage

// File: rtl/bwe_guard.sv
module bwe_guard
  import bwe_pkg::*;
#(
  parameter int unsigned RSC_CYC = 2,
  parameter int unsigned BWC_CYC = 2,
  parameter int unsigned BPL_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  op_e  op,
  input  logic ld_fire,
  input  logic bw_any_fire,
  input  logic bw_plain_fire,
  output logic viol,
  output logic err_q
);

  localparam int unsigned MAX_AB = (RSC_CYC > BWC_CYC) ? RSC_CYC : BWC_CYC;
  localparam int unsigned MAXC   = (MAX_AB > BPL_CYC) ? MAX_AB : BPL_CYC;
  localparam int unsigned CNT_W  = $clog2(MAXC + 1);

  logic [CNT_W-1:0] rsc_cnt, bwc_cnt, bpl_cnt;
  logic             heavy;

  assign heavy = (op == OP_WR) || (op == OP_BW) || (op == OP_BWAP) || (op == OP_LOAD);
  assign viol  = (op != OP_NOP) &&
                 ((rsc_cnt != '0) ||
                  (heavy && (bwc_cnt != '0)) ||
                  ((op == OP_PRE) && (bpl_cnt != '0)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsc_cnt <= '0;
      bwc_cnt <= '0;
      bpl_cnt <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= viol;
      if (ld_fire)              rsc_cnt <= CNT_W'(RSC_CYC - 1);
      else if (rsc_cnt != '0)   rsc_cnt <= rsc_cnt - 1'b1;
      if (bw_any_fire)          bwc_cnt <= CNT_W'(BWC_CYC - 1);
      else if (bwc_cnt != '0)   bwc_cnt <= bwc_cnt - 1'b1;
      if (bw_plain_fire)        bpl_cnt <= CNT_W'(BPL_CYC - 1);
      else if (bpl_cnt != '0)   bpl_cnt <= bpl_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/bwe_regs.sv
module bwe_regs
  import bwe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_fire,
  input  logic            sel_mask,
  input  logic [DQ_W-1:0] din,
  output logic [DQ_W-1:0] color_q,
  output logic [DQ_W-1:0] plane_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      color_q <= '0;
      plane_q <= '1;
    end else if (ld_fire) begin
      if (sel_mask) plane_q <= din;
      else          color_q <= din;
    end
  end

endmodule

// File: rtl/bwe_array.sv
module bwe_array
  import bwe_pkg::*;
#(
  parameter int unsigned COL_W    = 5,
  parameter int unsigned BLK_COLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic             bw_fire,
  input  logic             rd_fire,
  input  logic [COL_W-1:0] col,
  input  logic [DQ_W-1:0]  dq,
  input  logic [LANES-1:0] dqm,
  input  logic [DQ_W-1:0]  color,
  input  logic [DQ_W-1:0]  plane,
  output logic [DQ_W-1:0]  rd_data,
  output logic             rd_valid
);

  localparam int unsigned DEPTH = 1 << COL_W;
  localparam int unsigned BLK_W = $clog2(BLK_COLS);
  localparam int unsigned GRP_W = COL_W - BLK_W;

  logic [DEPTH-1:0][DQ_W-1:0] words;
  logic [DQ_W-1:0]            en;
  logic [GRP_W-1:0]           grp;

  assign en  = bit_enable(plane, dqm);
  assign grp = col[COL_W-1:BLK_W];

  for (genvar c = 0; c < DEPTH; c++) begin : g_col
    localparam int unsigned             KIDX = c % BLK_COLS;
    localparam logic [GRP_W-1:0]        GIDX = GRP_W'(c / BLK_COLS);
    logic            hit_wr, hit_bw;
    logic [DQ_W-1:0] word_q;

    assign hit_wr = wr_fire && (col == COL_W'(c));
    assign hit_bw = bw_fire && (grp == GIDX) && dq[KIDX];

    always_ff @(posedge clk) begin
      if (!rst_n)      word_q <= '0;
      else if (hit_bw) word_q <= merge_word(word_q, color, en);
      else if (hit_wr) word_q <= merge_word(word_q, dq, en);
    end

    assign words[c] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= words[col];
    end
  end

endmodule

// File: rtl/bwe_engine.sv
module bwe_engine
  import bwe_pkg::*;
#(
  parameter int unsigned COL_W    = 5,
  parameter int unsigned BLK_COLS = 8,
  parameter int unsigned RSC_CYC  = 2,
  parameter int unsigned BWC_CYC  = 2,
  parameter int unsigned BPL_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd,
  input  logic [COL_W-1:0] col_addr,
  input  logic [31:0]      dq_in,
  input  logic [3:0]       dqm,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic             row_open,
  output logic             timing_err
);

  op_e             op;
  logic            viol, ok;
  logic            ld_fire, wr_fire, bw_fire, bw_plain_fire, bwap_fire, rd_fire;
  logic            row_q;
  logic [DQ_W-1:0] color_q, plane_q;

  assign op            = op_e'(cmd);
  assign ok            = !viol;
  assign ld_fire       = ok && (op == OP_LOAD);
  assign wr_fire       = ok && row_q && (op == OP_WR);
  assign bw_plain_fire = ok && row_q && (op == OP_BW);
  assign bwap_fire     = ok && row_q && (op == OP_BWAP);
  assign bw_fire       = bw_plain_fire || bwap_fire;
  assign rd_fire       = ok && row_q && (op == OP_RD);

  always_ff @(posedge clk) begin
    if (!rst_n)                      row_q <= 1'b0;
    else if (ok && (op == OP_ACT))   row_q <= 1'b1;
    else if (ok && (op == OP_PRE))   row_q <= 1'b0;
    else if (bwap_fire)              row_q <= 1'b0;
  end

  bwe_guard #(
    .RSC_CYC(RSC_CYC), .BWC_CYC(BWC_CYC), .BPL_CYC(BPL_CYC)
  ) guard_i (
    .clk(clk), .rst_n(rst_n), .op(op),
    .ld_fire(ld_fire), .bw_any_fire(bw_fire), .bw_plain_fire(bw_plain_fire),
    .viol(viol), .err_q(timing_err)
  );

  bwe_regs regs_i (
    .clk(clk), .rst_n(rst_n), .ld_fire(ld_fire), .sel_mask(col_addr[0]),
    .din(dq_in), .color_q(color_q), .plane_q(plane_q)
  );

  bwe_array #(
    .COL_W(COL_W), .BLK_COLS(BLK_COLS)
  ) array_i (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .bw_fire(bw_fire), .rd_fire(rd_fire),
    .col(col_addr), .dq(dq_in), .dqm(dqm), .color(color_q), .plane(plane_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign row_open = row_q;

endmodule

// File: rtl/bwe_engine_chk.sv
module bwe_engine_chk #(
  parameter int unsigned RSC_CYC = 2,
  parameter int unsigned BWC_CYC = 2,
  parameter int unsigned BPL_CYC = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cmd,
  input logic        timing_err,
  input logic        rd_valid,
  input logic        row_open,
  input logic        viol,
  input logic        ld_fire,
  input logic        wr_fire,
  input logic        bw_fire,
  input logic        bwap_fire,
  input logic        bw_plain_fire,
  input logic        rd_fire,
  input logic [31:0] color_q,
  input logic [31:0] plane_q
);

  // R11
  err_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |-> ($past(cmd) != 3'd0));

  // R11
  viol_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> timing_err);

  // R5
  load_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && (RSC_CYC > 1)) |=> ((cmd == 3'd0) || viol));

  // R9
  bw_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_fire && (BWC_CYC > 1)) |=> !(wr_fire || bw_fire || ld_fire));

  // R9
  bpl_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_plain_fire && (BPL_CYC > 1)) |=> ((cmd != 3'd6) || viol));

  // R2
  single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_fire, wr_fire, bw_fire, rd_fire}));

  // R4
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_fire |=> ($stable(color_q) && $stable(plane_q)));

  // R8
  auto_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bwap_fire |=> !row_open);

  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid);

  // R10
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rd_valid);

endmodule

bind bwe_engine bwe_engine_chk #(
  .RSC_CYC(RSC_CYC), .BWC_CYC(BWC_CYC), .BPL_CYC(BPL_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .timing_err(timing_err), .rd_valid(rd_valid),
  .row_open(row_open), .viol(viol), .ld_fire(ld_fire), .wr_fire(wr_fire),
  .bw_fire(bw_fire), .bwap_fire(bwap_fire), .bw_plain_fire(bw_plain_fire),
  .rd_fire(rd_fire), .color_q(color_q), .plane_q(plane_q)
);

// File: tb/bwe_engine_tb_top.sv
`timescale 1ns/1ps
module bwe_engine_tb_top;

  typedef struct packed {
    logic [2:0]  op;
    logic [4:0]  col;
    logic [31:0] dq;
    logic [3:0]  dqm;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 5'd0,  32'h0,          4'h0, 1'b0, 8'd2},   // R2 open
    '{3'd2, 5'd3,  32'hA5A5_1234,  4'h0, 1'b0, 8'd3},   // R3 plain write
    '{3'd7, 5'd3,  32'h0,          4'h0, 1'b0, 8'd10},  // R10 read back
    '{3'd5, 5'd0,  32'hCAFE_F00D,  4'h0, 1'b0, 8'd4},   // R4 colour
    '{3'd0, 5'd0,  32'h0,          4'h0, 1'b0, 8'd5},   // R5 wait
    '{3'd5, 5'd1,  32'hFFFF_00FF,  4'h0, 1'b0, 8'd4},   // R4 mask
    '{3'd0, 5'd0,  32'h0,          4'h0, 1'b0, 8'd5},
    '{3'd3, 5'd13, 32'h0000_00A5,  4'h0, 1'b0, 8'd6},   // R6 base 8
    '{3'd0, 5'd0,  32'h0,          4'h0, 1'b0, 8'd9},
    '{3'd7, 5'd8,  32'h0,          4'h0, 1'b0, 8'd6},   // R6 enabled
    '{3'd7, 5'd9,  32'h0,          4'h0, 1'b0, 8'd6},   // R6 disabled
    '{3'd7, 5'd13, 32'h0,          4'h0, 1'b0, 8'd7},   // R7
    '{3'd2, 5'd3,  32'hFFFF_FFFF,  4'h5, 1'b0, 8'd3},   // R3 lanes + mask
    '{3'd7, 5'd3,  32'h0,          4'h0, 1'b0, 8'd3},
    '{3'd3, 5'd16, 32'h0000_00FF,  4'h8, 1'b0, 8'd7},   // R7 lane 3 off
    '{3'd2, 5'd0,  32'hFFFF_FFFF,  4'h0, 1'b1, 8'd9},   // R9 too early
    '{3'd6, 5'd0,  32'h0,          4'h0, 1'b1, 8'd9},   // R9 close too early
    '{3'd7, 5'd16, 32'h0,          4'h0, 1'b0, 8'd7},
    '{3'd7, 5'd0,  32'h0,          4'h0, 1'b0, 8'd11},  // R11 dropped write
    '{3'd5, 5'd0,  32'h1234_5678,  4'h0, 1'b0, 8'd4},
    '{3'd7, 5'd16, 32'h0,          4'h0, 1'b1, 8'd5},   // R5 violation
    '{3'd4, 5'd24, 32'h0000_0081,  4'h0, 1'b0, 8'd8},   // R8
    '{3'd0, 5'd0,  32'h0,          4'h0, 1'b0, 8'd8},
    '{3'd0, 5'd0,  32'h0,          4'h0, 1'b0, 8'd8},
    '{3'd7, 5'd24, 32'h0,          4'h0, 1'b0, 8'd2},   // R2 closed read
    '{3'd1, 5'd0,  32'h0,          4'h0, 1'b0, 8'd2},
    '{3'd7, 5'd24, 32'h0,          4'h0, 1'b0, 8'd4},   // R4 persistence
    '{3'd7, 5'd31, 32'h0,          4'h0, 1'b0, 8'd6},
    '{3'd6, 5'd0,  32'h0,          4'h0, 1'b0, 8'd2},
    '{3'd2, 5'd5,  32'hFFFF_FFFF,  4'h0, 1'b0, 8'd2},   // R2 closed write
    '{3'd1, 5'd0,  32'h0,          4'h0, 1'b0, 8'd2},
    '{3'd7, 5'd5,  32'h0,          4'h0, 1'b0, 8'd2},
    '{3'd5, 5'd1,  32'hFFFF_FFFF,  4'h0, 1'b0, 8'd4},
    '{3'd0, 5'd0,  32'h0,          4'h0, 1'b0, 8'd5},
    '{3'd3, 5'd0,  32'h0000_0001,  4'h0, 1'b0, 8'd6},
    '{3'd0, 5'd0,  32'h0,          4'h0, 1'b0, 8'd9},
    '{3'd7, 5'd0,  32'h0,          4'h0, 1'b0, 8'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [4:0]  col_addr = '0;
  logic [31:0] dq_in = '0;
  logic [3:0]  dqm = '0;
  logic [31:0] rd_data;
  logic        rd_valid, row_open, timing_err;

  int total = 0;
  int bad = 0;

  logic [31:0] ref_mem [32];
  logic [31:0] ref_color, ref_plane;
  logic        ref_open;

  always #2 clk = ~clk;

  bwe_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .col_addr(col_addr), .dq_in(dq_in),
    .dqm(dqm), .rd_data(rd_data), .rd_valid(rd_valid), .row_open(row_open),
    .timing_err(timing_err)
  );

  task automatic check(input int req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [4:0] a,
                       input logic [31:0] d, input logic [3:0] m);
    cmd = c; col_addr = a; dq_in = d; dqm = m;
    @(negedge clk);
    cmd = 3'd0;
  endtask

  // Bit-level write: bit b changes when plane bit set and its lane unmasked.
  function automatic logic [31:0] model_put(input logic [31:0] old_w, input logic [31:0] val,
                                            input logic [3:0] m);
    logic [31:0] r = old_w;
    for (int b = 0; b < 32; b++) begin
      if (ref_plane[b] && !m[b/8]) r[b] = val[b];
    end
    return r;
  endfunction

  initial begin : main
    for (int i = 0; i < 32; i++) ref_mem[i] = '0;
    ref_color = '0; ref_plane = 32'hFFFF_FFFF; ref_open = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, "row_open at reset", {31'd0, row_open}, 32'd0);
    check(1, "timing_err at reset", {31'd0, timing_err}, 32'd0);
    check(1, "rd_valid at reset", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic exp_rv;
      v = VECS[i];
      drive(v.op, v.col, v.dq, v.dqm);
      exp_rv = (v.op == 3'd7) && !v.err && ref_open;
      check(int'(v.req), "timing_err", {31'd0, timing_err}, {31'd0, v.err});
      check(int'(v.req), "rd_valid", {31'd0, rd_valid}, {31'd0, exp_rv});
      if (exp_rv) check(int'(v.req), "rd_data", rd_data, ref_mem[v.col]);
      if (!v.err) begin
        case (v.op)
          3'd1: ref_open = 1'b1;
          3'd6: ref_open = 1'b0;
          3'd2: if (ref_open) ref_mem[v.col] = model_put(ref_mem[v.col], v.dq, v.dqm);
          3'd3, 3'd4: if (ref_open) begin
            for (int k = 0; k < 8; k++) begin
              if (v.dq[k]) ref_mem[{v.col[4:3], 3'b000} + k] =
                  model_put(ref_mem[{v.col[4:3], 3'b000} + k], ref_color, v.dqm);
            end
            if (v.op == 3'd4) ref_open = 1'b0;
          end
          3'd5: if (v.col[0]) ref_plane = v.dq; else ref_color = v.dq;
          default: ;
        endcase
      end
      check(int'(v.req), "row_open", {31'd0, row_open}, {31'd0, ref_open});
    end

    // Directed: R1 reset mid-run restores register and array defaults
    rst_n = 1'b0;
    @(negedge clk);
    check(1, "row_open after reset", {31'd0, row_open}, 32'd0);
    check(1, "rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    drive(3'd1, 5'd0, 32'h0, 4'h0);
    drive(3'd2, 5'd2, 32'hFFFF_FFFF, 4'h0);
    drive(3'd7, 5'd2, 32'h0, 4'h0);
    check(1, "mask reset all ones", rd_data, 32'hFFFF_FFFF);
    drive(3'd3, 5'd0, 32'h0000_0004, 4'h0);
    drive(3'd7, 5'd2, 32'h0, 4'h0);
    check(1, "colour reset zero", rd_data, 32'h0);
    drive(3'd7, 5'd8, 32'h0, 4'h0);
    check(1, "array reset zero", rd_data, 32'h0);
    // R11 pulse lasts one cycle
    drive(3'd5, 5'd0, 32'h1, 4'h0);
    drive(3'd1, 5'd0, 32'h0, 4'h0);
    check(11, "err pulse", {31'd0, timing_err}, 32'd1);
    drive(3'd0, 5'd0, 32'h0, 4'h0);
    check(11, "err clears", {31'd0, timing_err}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule